// File: doc/BRIEF.md
# I2C Random-Read Master

This block is an I2C bus master that fetches one byte from a memory-type slave at a chosen 8-bit word address. A one-cycle request carries the word address. The block then plays the whole random-read exchange on the bus. It first issues a start and the device address with the write flag, then sends the word address. A repeated start follows, then the device address with the read flag. The slave returns one byte, the master answers it with a not-acknowledge, and a stop ends the exchange. A one-cycle done pulse then presents the byte.

Every bus bit lasts `BIT_CYC` system clocks. A counter places the clock and data edges at fixed fractions of that period, so one parameter sets the bus rate. SCL is a push-pull output. SDA is open-drain: an enable pulls the line low and an input returns its level. When any of the three address bytes is not acknowledged, the master drops the exchange at once, releases both lines and raises an error flag.

Top module: `i2c_eeprom_rd`

## Requirements
- R1: After reset and whenever idle, SCL is high, SDA is released (`sda_oe_o` = 0), and `done_o` and `err_o` are 0.
- R2: A start or repeated start pulls SDA low while SCL is high, and SCL falls 2·`BIT_CYC`/5 clocks after that SDA fall.
- R3: Each transmitted or received bit holds SCL high for 2·`BIT_CYC`/5 clocks, and SDA never changes while SCL is high during a bit.
- R4: The bytes sent are 0xA0 (device address 1010000, R/W = 0), then the word address, then 0xA1 (R/W = 1), each most significant bit first.
- R5: In each acknowledge slot of an address byte, SDA is released. A high sample (NACK) ends the exchange with `err_o` = 1, no stop condition and no done pulse, and both lines are released.
- R6: Between the word address and the read address, the master releases SDA while SCL is low, raises SCL, and then issues a repeated start.
- R7: The read byte is sampled from SDA during 8 clock pulses, most significant bit first. SDA stays released (NACK) in the ninth pulse.
- R8: A full exchange has exactly 36 bit pulses and three SDA edges while SCL is high: the start fall, the repeated-start fall and the stop rise.
- R9: After the stop, `done_o` is high for exactly one clock, with `data_o` equal to the byte read and `err_o` = 0.
- R10: A request that arrives while an exchange is running is ignored.
- R11: Reset during an exchange returns the block to idle with both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | One-cycle read request |
| word_i | input | 8 | Word address taken with the request |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_o | output | 1 | SCL, push-pull |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| done_o | output | 1 | One-cycle pulse when the read byte is valid |
| err_o | output | 1 | Set when an address byte is not acknowledged; cleared by the next request |
| data_o | output | 8 | Byte read from the slave |

## Verification
A wrong phase or byte index in the sequencer shows up on the bus within one bit period. It appears as a wrong byte at the bench's slave model, a missing repeated start, or a wrong count of SCL pulses or SDA edges while SCL is high. A counter that drifts or an edge point set wrongly changes the measured SCL-high width or the start-to-SCL-fall gap on the very next pulse. A bad shift or sample point reaches `data_o` at the done pulse of the same exchange. The bench sweeps 64 word addresses spread over the whole range, a NACK on each of the three address bytes, a request made while busy, and a reset in mid-exchange.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

    localparam int BYTE_W = 8;
    localparam int DEV_W  = 7;
    localparam logic [DEV_W-1:0] DEV_ADDR = 7'b1010000;

    typedef enum logic [2:0] {
        PH_IDLE, PH_START, PH_BIT, PH_RSTART, PH_STOP, PH_DONE
    } phase_e;

    typedef enum logic [1:0] {
        BY_DEVW, BY_WORD, BY_DEVR, BY_READ
    } byte_e;

    typedef struct packed {
        logic scl;
        logic oe;
    } line_t;

    function automatic logic [BYTE_W-1:0] dev_byte(input logic rd);
        return {DEV_ADDR, rd};
    endfunction

endpackage

// File: rtl/i2c_rd_bit_timer.sv
module i2c_rd_bit_timer #(
    parameter int BIT_CYC = 250,
    localparam int CW = $clog2(BIT_CYC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    output logic [CW-1:0] cnt_o,
    output logic          last_o
);
    localparam logic [CW-1:0] LAST = CW'(BIT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i || cnt_q == LAST) cnt_q <= '0;
        else                                cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign last_o = run_i && (cnt_q == LAST);

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        last_o |=> (cnt_o == '0));

endmodule

// File: rtl/i2c_rd_seq.sv
module i2c_rd_seq
    import i2c_rd_pkg::*;
#(
    parameter int BIT_CYC = 250,
    localparam int CW = $clog2(BIT_CYC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [BYTE_W-1:0] word_i,
    input  logic              sda_i,
    input  logic [CW-1:0]     cnt_i,
    input  logic              last_i,
    output phase_e            ph_o,
    output logic              run_o,
    output logic              data_low_o,
    output logic              done_o,
    output logic              err_o,
    output logic [BYTE_W-1:0] data_o
);
    localparam logic [CW-1:0] SAMP = CW'(2 * BIT_CYC / 5);
    localparam logic [3:0]    ACK_SLOT = 4'(BYTE_W);

    phase_e            ph_q;
    byte_e             by_q;
    logic [3:0]        bit_q;
    logic [BYTE_W-1:0] sh_q, word_q, data_q;
    logic              ack_q, err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            by_q   <= BY_DEVW;
            bit_q  <= '0;
            sh_q   <= '0;
            word_q <= '0;
            data_q <= '0;
            ack_q  <= 1'b1;
            err_q  <= 1'b0;
        end else begin
            unique case (ph_q)
                PH_IDLE: if (req_i) begin
                    word_q <= word_i;
                    sh_q   <= dev_byte(1'b0);
                    by_q   <= BY_DEVW;
                    bit_q  <= '0;
                    err_q  <= 1'b0;
                    ph_q   <= PH_START;
                end
                PH_START:  if (last_i) ph_q <= PH_BIT;
                PH_RSTART: if (last_i) ph_q <= PH_BIT;
                PH_STOP:   if (last_i) ph_q <= PH_DONE;
                PH_BIT: begin
                    if (cnt_i == SAMP) begin
                        if (bit_q == ACK_SLOT)    ack_q <= sda_i;
                        else if (by_q == BY_READ) sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
                    end
                    if (last_i) begin
                        if (bit_q != ACK_SLOT) begin
                            bit_q <= bit_q + 1'b1;
                            if (by_q != BY_READ) sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
                        end else begin
                            bit_q <= '0;
                            if (by_q == BY_READ) begin
                                data_q <= sh_q;
                                ph_q   <= PH_STOP;
                            end else if (ack_q) begin
                                err_q <= 1'b1;
                                ph_q  <= PH_IDLE;
                            end else begin
                                unique case (by_q)
                                    BY_DEVW: begin
                                        by_q <= BY_WORD;
                                        sh_q <= word_q;
                                    end
                                    BY_WORD: begin
                                        by_q <= BY_DEVR;
                                        sh_q <= dev_byte(1'b1);
                                        ph_q <= PH_RSTART;
                                    end
                                    default: by_q <= BY_READ;
                                endcase
                            end
                        end
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign ph_o       = ph_q;
    assign run_o      = ph_q inside {PH_START, PH_BIT, PH_RSTART, PH_STOP};
    assign data_low_o = (ph_q == PH_BIT) && (by_q != BY_READ) &&
                        (bit_q != ACK_SLOT) && !sh_q[BYTE_W-1];
    assign done_o     = (ph_q == PH_DONE);
    assign err_o      = err_q;
    assign data_o     = data_q;

endmodule

// File: rtl/i2c_rd_line_gen.sv
module i2c_rd_line_gen
    import i2c_rd_pkg::*;
#(
    parameter int BIT_CYC = 250,
    localparam int CW = $clog2(BIT_CYC)
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        ph_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          data_low_i,
    output logic          scl_o,
    output logic          sda_oe_o
);
    localparam logic [CW-1:0] E1 = CW'(BIT_CYC / 5);
    localparam logic [CW-1:0] E2 = CW'(2 * BIT_CYC / 5);
    localparam logic [CW-1:0] E3 = CW'(3 * BIT_CYC / 5);
    localparam logic [CW-1:0] E4 = CW'(4 * BIT_CYC / 5);

    line_t nxt, cur_q;
    logic  bitph_q;

    always_comb begin
        nxt = '{scl: 1'b1, oe: 1'b0};
        unique case (ph_i)
            PH_START:  nxt = '{scl: cnt_i < E4, oe: cnt_i >= E2};
            PH_BIT:    nxt = '{scl: (cnt_i >= E1) && (cnt_i < E3), oe: data_low_i};
            PH_RSTART: nxt = '{scl: (cnt_i >= E1) && (cnt_i < E4), oe: cnt_i >= E2};
            PH_STOP:   nxt = '{scl: cnt_i >= E1, oe: cnt_i < E3};
            default:   nxt = '{scl: 1'b1, oe: 1'b0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '{scl: 1'b1, oe: 1'b0};
            bitph_q <= 1'b0;
        end else begin
            cur_q   <= nxt;
            bitph_q <= (ph_i == PH_BIT);
        end
    end

    assign scl_o    = cur_q.scl;
    assign sda_oe_o = cur_q.oe;

    // R3
    sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_o && $past(scl_o) && bitph_q && $past(bitph_q)) |-> $stable(sda_oe_o));

endmodule

// File: rtl/i2c_eeprom_rd.sv
module i2c_eeprom_rd
    import i2c_rd_pkg::*;
#(
    parameter int BIT_CYC = 250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [BYTE_W-1:0] word_i,
    input  logic              sda_i,
    output logic              scl_o,
    output logic              sda_oe_o,
    output logic              done_o,
    output logic              err_o,
    output logic [BYTE_W-1:0] data_o
);
    localparam int CW = $clog2(BIT_CYC);

    logic [CW-1:0] cnt;
    logic          last, run, data_low;
    phase_e        ph;

    i2c_rd_bit_timer #(.BIT_CYC(BIT_CYC)) timer_i (
        .clk(clk), .rst(rst), .run_i(run), .cnt_o(cnt), .last_o(last)
    );

    i2c_rd_seq #(.BIT_CYC(BIT_CYC)) seq_i (
        .clk(clk), .rst(rst), .req_i(req_i), .word_i(word_i), .sda_i(sda_i),
        .cnt_i(cnt), .last_i(last), .ph_o(ph), .run_o(run),
        .data_low_o(data_low), .done_o(done_o), .err_o(err_o), .data_o(data_o)
    );

    i2c_rd_line_gen #(.BIT_CYC(BIT_CYC)) lines_i (
        .clk(clk), .rst(rst), .ph_i(ph), .cnt_i(cnt), .data_low_i(data_low),
        .scl_o(scl_o), .sda_oe_o(sda_oe_o)
    );

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (scl_o && !sda_oe_o));

    // R5
    abort_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |=> (scl_o && !sda_oe_o && !done_o));

endmodule

// File: tb/i2c_eeprom_rd_tb_top.sv
module i2c_eeprom_rd_tb_top;

    localparam int P   = 20;
    localparam int HI  = 3 * P / 5 - P / 5;
    localparam int GAP = 4 * P / 5 - 2 * P / 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic [7:0] word = '0;
    logic scl, sda_oe, done, err;
    logic [7:0] data;
    logic pull = 1'b0;
    logic sda_bus;

    always #2.5 clk = ~clk;

    assign sda_bus = ~(sda_oe | pull);

    i2c_eeprom_rd #(.BIT_CYC(P)) dut_i (
        .clk(clk), .rst(rst), .req_i(req), .word_i(word), .sda_i(sda_bus),
        .scl_o(scl), .sda_oe_o(sda_oe), .done_o(done), .err_o(err), .data_o(data)
    );

    int n_vec = 0;
    int n_bad = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] memf(input logic [7:0] a);
        return (a * 8'd37 + 8'd11) ^ 8'hA5;
    endfunction

    // slave model and bus monitor
    logic [2:0] ack_en = 3'b111;
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    int   bc = 0, nbytes = 0, idle_run = 0;
    logic [7:0] sh = '0;
    logic [7:0] rx [0:3];
    logic rd_phase = 1'b0, rd_pend = 1'b0, mst_ack = 1'b0;
    int   hi_len = 0, gap = 0;
    logic gap_run = 1'b0;
    int   n_pulse = 0, n_sfall = 0, n_srise = 0, n_badgap = 0;

    always @(negedge clk) begin
        if (prev_scl) hi_len++;
        if (gap_run) gap++;
        if (prev_scl && scl && prev_sda && !sda_bus) begin
            n_sfall++;
            gap_run = 1'b1;
            gap = 0;
            if (idle_run > P / 2) nbytes = 0;
            bc = -1;
            rd_phase = 1'b0;
            rd_pend = 1'b0;
            pull = 1'b0;
        end
        if (prev_scl && scl && !prev_sda && sda_bus) n_srise++;
        if (!prev_scl && scl) begin
            hi_len = 0;
            if (rd_phase) begin
                if (bc == 8) mst_ack = sda_bus;
            end else if (bc >= 0 && bc < 8) sh = {sh[6:0], sda_bus};
        end
        if (prev_scl && !scl) begin
            if (hi_len == HI) n_pulse++;
            if (gap_run) begin
                if (gap != GAP) n_badgap++;
                gap_run = 1'b0;
            end
            bc++;
            if (!rd_phase) begin
                if (bc == 8) begin
                    if (nbytes < 4) rx[nbytes] = sh;
                    pull = (nbytes < 3) ? ack_en[nbytes] : 1'b0;
                    rd_pend = (nbytes == 2) && sh[0] && ack_en[2];
                end else if (bc == 9) begin
                    bc = 0;
                    nbytes++;
                    pull = 1'b0;
                    if (rd_pend) begin
                        rd_phase = 1'b1;
                        rd_pend = 1'b0;
                        pull = ~memf(rx[1])[7];
                    end
                end
            end else begin
                if (bc >= 1 && bc <= 7) pull = ~memf(rx[1])[7 - bc];
                else pull = 1'b0;
            end
        end
        idle_run = (scl && sda_bus) ? idle_run + 1 : 0;
        prev_scl = scl;
        prev_sda = sda_bus;
    end

    task automatic run_read(input logic [7:0] addr, input bit inject);
        int b_pulse = n_pulse, b_fall = n_sfall, b_rise = n_srise, b_gap = n_badgap;
        int dones = 0;
        logic [7:0] got = '0;
        logic got_err = 1'b1;
        @(negedge clk); req = 1'b1; word = addr;
        @(negedge clk); req = 1'b0; word = '0;
        for (int c = 0; c < 45 * P && dones == 0; c++) begin
            @(negedge clk);
            if (inject && c == 5 * P) begin req = 1'b1; word = ~addr; end
            else begin req = 1'b0; word = '0; end
            if (done) begin dones++; got = data; got_err = err; end
        end
        for (int c = 0; c < 2 * P; c++) begin
            @(negedge clk);
            if (done) dones++;
        end
        check("R9 done count", dones, 1);
        check(inject ? "R10 data despite busy request" : "R7 read data", got, memf(addr));
        check("R9 err at done", got_err, 0);
        check("R4 byte0", rx[0], 8'hA0);
        check(inject ? "R10 word addr" : "R4 word addr", rx[1], addr);
        check("R4 byte2", rx[2], 8'hA1);
        check("R7 master NACK", mst_ack, 1);
        check("R8 bit pulses", n_pulse - b_pulse, 36);
        check("R6 start falls", n_sfall - b_fall, 2);
        check("R8 stop rises", n_srise - b_rise, 1);
        check("R2 start to SCL gap", n_badgap - b_gap, 0);
        check("R1 idle lines", {scl, sda_oe}, 2'b10);
    endtask

    task automatic run_abort(input int k);
        int b_pulse = n_pulse, b_rise = n_srise;
        int dones = 0;
        ack_en = 3'b111;
        ack_en[k] = 1'b0;
        @(negedge clk); req = 1'b1; word = 8'h3C;
        @(negedge clk); req = 1'b0;
        for (int c = 0; c < 45 * P; c++) begin
            @(negedge clk);
            if (done) dones++;
        end
        check("R5 err set", err, 1);
        check("R5 no done", dones, 0);
        check("R5 bytes seen", nbytes, k + 1);
        check("R5 pulses", n_pulse - b_pulse, 9 * (k + 1));
        check("R5 no stop", n_srise - b_rise, 0);
        check("R5 lines released", {scl, sda_oe}, 2'b10);
        ack_en = 3'b111;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset scl", scl, 1);
        check("R1 reset sda_oe", sda_oe, 0);
        check("R1 reset done", done, 0);
        check("R1 reset err", err, 0);
        repeat (P) @(negedge clk);

        for (int k = 0; k < 64; k++) run_read(8'(k * 4 + (k & 3)), 1'b0);
        run_read(8'h5A, 1'b1);
        for (int k = 0; k < 3; k++) begin
            run_abort(k);
            run_read(8'(8'h11 * (k + 1)), 1'b0);
        end

        @(negedge clk); req = 1'b1; word = 8'h77;
        @(negedge clk); req = 1'b0;
        repeat (10 * P + P / 2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 scl after reset", scl, 1);
        check("R11 sda_oe after reset", sda_oe, 0);
        check("R11 done after reset", done, 0);
        repeat (2 * P) @(negedge clk);
        run_read(8'hC3, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule